// File: doc/BRIEF.md
# Console Serial Register Interface

This block gives a processor a small memory-mapped console port. The port has two status registers and two data registers. Received characters come in on a valid/ready byte stream and wait in a one-entry holding register until software reads them. Characters that software writes leave on a byte output qualified by a valid pulse. The transmitter never pushes back, so its ready flag always reads as set. Bit-level serial framing is not part of this block.

The block raises a vectored interrupt. A receive request is made when its enable is set and a character is waiting. A transmit request is made whenever its enable is set. Either request sets a sticky pending flag, which the block presents at bit 28 of a 32-bit system status word. The same flag drives a level interrupt request line, and an 8-bit vector says which source asked. Software acknowledges the interrupt by writing either status register.

Top module: `console_port_regs`

## Requirements
- R1: After reset, `rx_ready` is 1 and `tx_valid`, `irq`, `irq_vector`, `sys_status` and `bus_rdata` are all 0.
- R2: A read of byte offset 0x80 (receive status) returns bit 7 = a character is held and bit 6 = receive interrupt enable, with all other bits 0. A write stores only bit 6. Bit 7 follows the holding register and ignores the written value.
- R3: A read of offset 0x88 (transmit status) always returns bit 7 = 1 and bit 6 = transmit interrupt enable, with all other bits 0. A write stores only bit 6.
- R4: The receive side holds one character. `rx_ready` is low while a character is held, and input offered in that time is dropped. A read of offset 0x84 returns the held character in bits 7:0 with the upper bits 0, and frees the holding register. With nothing held, that read returns 0.
- R5: While the receive enable is set and a character is held, `irq` and `sys_status[28]` become 1 one cycle later, with `irq_vector` = 0xF8.
- R6: While the transmit enable is set, `irq` and `sys_status[28]` become 1 one cycle later, with `irq_vector` = 0xFC. When both conditions hold, the vector is 0xFC.
- R7: Once set, the pending flag stays set after its condition goes away. A write to offset 0x80 or 0x88 clears `irq` and `sys_status[28]` on the next cycle. If a condition still holds, they are set again one cycle after that.
- R8: A write to offset 0x8C produces a one-cycle `tx_valid` pulse in the next cycle. `tx_data` carries bits 7:0 of the write data.
- R9: A read of offset 0x100 returns 128. A read of any other unmapped offset, or of 0x108, returns 0. Writes to 0x100, to 0x108 and to unmapped offsets change no state.
- R10: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Incoming character is offered |
| rx_data | input | 8 | Incoming character |
| rx_ready | output | 1 | Holding register is empty |
| tx_valid | output | 1 | Outgoing character strobe |
| tx_data | output | 8 | Outgoing character |
| irq | output | 1 | Interrupt request, level |
| irq_vector | output | 8 | Vector of the last request (0xF8 receive, 0xFC transmit) |
| sys_status | output | 32 | System status word, pending flag at bit 28 |

## Verification
A wrong holding-register flag shows in three places. It shows at `rx_ready` in the same cycle. It shows in bit 7 of the next receive status read. It shows at `irq` one cycle after the receive enable is set. A stale pending flag or vector shows at `irq` or `irq_vector` within one cycle of a status write or a change in condition. The bench therefore samples these outputs in the exact cycle after each access. A lost enable bit shows in the status readback and in a missing interrupt. A consume that fails to happen shows as the same character returned twice.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  // Byte offsets of the register window.
  localparam int unsigned OFF_RXSTAT  = 32'h080;
  localparam int unsigned OFF_RXDATA  = 32'h084;
  localparam int unsigned OFF_TXSTAT  = 32'h088;
  localparam int unsigned OFF_TXDATA  = 32'h08C;
  localparam int unsigned OFF_CONST   = 32'h100;
  localparam int unsigned OFF_SINK    = 32'h108;

  // Status register bit positions.
  localparam int unsigned BIT_IE      = 6;
  localparam int unsigned BIT_FLAG    = 7;

  // Interrupt vectors and the pending flag position.
  localparam logic [7:0]  VEC_RX      = 8'hF8;
  localparam logic [7:0]  VEC_TX      = 8'hFC;
  localparam int unsigned PEND_BIT    = 28;
  localparam int unsigned CONST_VALUE = 128;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXSTAT,
    SEL_RXDATA,
    SEL_TXSTAT,
    SEL_TXDATA,
    SEL_CONST,
    SEL_SINK
  } cpr_sel_e;
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output cpr_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_RXSTAT)) sel = SEL_RXSTAT;
    else if (addr == ADDR_W'(OFF_RXDATA)) sel = SEL_RXDATA;
    else if (addr == ADDR_W'(OFF_TXSTAT)) sel = SEL_TXSTAT;
    else if (addr == ADDR_W'(OFF_TXDATA)) sel = SEL_TXDATA;
    else if (addr == ADDR_W'(OFF_CONST))  sel = SEL_CONST;
    else if (addr == ADDR_W'(OFF_SINK))   sel = SEL_SINK;
  end
endmodule

// File: rtl/cpr_rx_hold.sv
module cpr_rx_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              consume,
  output logic              held,
  output logic [CHAR_W-1:0] char_q
);
  logic              held_q, held_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              data_en;

  assign in_ready = ~held_q;
  assign held     = held_q;
  assign char_q   = data_q;

  always_comb begin
    held_d  = held_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (in_valid && !held_q) begin
      held_d  = 1'b1;
      data_d  = in_data;
      data_en = 1'b1;
    end else if (consume) begin
      held_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      data_q <= '0;
    end else begin
      held_q <= held_d;
      if (data_en) data_q <= data_d;
    end
  end
endmodule

// File: rtl/cpr_irq.sv
module cpr_irq
  import cpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_req,
  input  logic       tx_req,
  input  logic       ack,
  output logic       pending,
  output logic [7:0] vector
);
  logic       pend_q, pend_d;
  logic [7:0] vec_q, vec_d;
  logic       vec_en;

  assign pending = pend_q;
  assign vector  = vec_q;

  // Acknowledge wins over a same-cycle request; the request re-arms next cycle.
  always_comb begin
    pend_d = pend_q;
    vec_d  = vec_q;
    vec_en = 1'b0;
    if (ack) begin
      pend_d = 1'b0;
    end else if (rx_req || tx_req) begin
      pend_d = 1'b1;
      vec_d  = tx_req ? VEC_TX : VEC_RX;
      vec_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (vec_en) vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/console_port_regs.sv
module console_port_regs
  import cpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq,
  output logic [7:0]        irq_vector,
  output logic [STAT_W-1:0] sys_status
);
  localparam int PEND_POS = PEND_BIT;

  cpr_sel_e          sel;
  logic              held;
  logic [CHAR_W-1:0] held_char;
  logic              pending;

  logic              rx_en_q, rx_en_d, tx_en_q, tx_en_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic              tx_valid_q, tx_valid_d;
  logic [CHAR_W-1:0] tx_data_q;

  logic wr_rxstat, wr_txstat, wr_txdata, rd_rxdata;

  cpr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_rxstat = bus_wr && (sel == SEL_RXSTAT);
  assign wr_txstat = bus_wr && (sel == SEL_TXSTAT);
  assign wr_txdata = bus_wr && (sel == SEL_TXDATA);
  assign rd_rxdata = bus_rd && (sel == SEL_RXDATA);

  cpr_rx_hold #(.CHAR_W(CHAR_W)) u_rx_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_ready (rx_ready),
    .consume  (rd_rxdata),
    .held     (held),
    .char_q   (held_char)
  );

  cpr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_req  (rx_en_q && held),
    .tx_req  (tx_en_q),
    .ack     (wr_rxstat || wr_txstat),
    .pending (pending),
    .vector  (irq_vector)
  );

  // Enable bits and the read mux.
  always_comb begin
    rx_en_d = wr_rxstat ? bus_wdata[BIT_IE] : rx_en_q;
    tx_en_d = wr_txstat ? bus_wdata[BIT_IE] : tx_en_q;
    rdata_d = '0;
    case (sel)
      SEL_RXSTAT: begin
        rdata_d[BIT_FLAG] = held;
        rdata_d[BIT_IE]   = rx_en_q;
      end
      SEL_RXDATA: if (held) rdata_d[CHAR_W-1:0] = held_char;
      SEL_TXSTAT: begin
        rdata_d[BIT_FLAG] = 1'b1;
        rdata_d[BIT_IE]   = tx_en_q;
      end
      SEL_CONST:  rdata_d = BUS_W'(CONST_VALUE);
      default:    rdata_d = '0;
    endcase
    tx_valid_d = wr_txdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q    <= 1'b0;
      tx_en_q    <= 1'b0;
      rdata_q    <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      rx_en_q    <= rx_en_d;
      tx_en_q    <= tx_en_d;
      tx_valid_q <= tx_valid_d;
      if (bus_rd)    rdata_q   <= rdata_d;
      if (wr_txdata) tx_data_q <= bus_wdata[CHAR_W-1:0];
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = tx_valid_q;
  assign tx_data   = tx_data_q;
  assign irq       = pending;

  always_comb begin
    sys_status           = '0;
    sys_status[PEND_POS] = pending;
  end
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [7:0]        irq_vector,
  input logic [STAT_W-1:0] sys_status
);
  a_r3_tx_ready_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(12'h088)) |=> bus_rdata[7]);

  a_r4_full_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  a_r7_ack_clears_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(12'h080) || bus_addr == ADDR_W'(12'h088)))
      |=> (!irq && !sys_status[28]));

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vector == 8'hF8 || irq_vector == 8'hFC));

  a_r8_tx_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12'h08C)) |=> tx_valid);

  a_r8_no_spurious_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(12'h08C)) |=> !tx_valid);

  a_r9_const_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(12'h100)) |=> bus_rdata == BUS_W'(128));

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind console_port_regs cpr_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W), .STAT_W(STAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .irq        (irq),
  .irq_vector (irq_vector),
  .sys_status (sys_status)
);

// File: tb/console_port_regs_tb.sv
module console_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data, irq_vector;
  logic        irq;
  logic [31:0] sys_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state, updated by the stimulus tasks.
  bit       m_held;
  bit [7:0] m_char;
  bit       m_rx_en, m_tx_en;

  always #2 clk = ~clk;

  console_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
    .irq_vector(irq_vector), .sys_status(sys_status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rxstat();
    return {24'h0, m_held, m_rx_en, 6'h0};
  endfunction
  function automatic logic [31:0] exp_txstat();
    return {24'h0, 1'b1, m_tx_en, 6'h0};
  endfunction
  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a)
      12'h080: return exp_rxstat();
      12'h084: return m_held ? {24'h0, m_char} : 32'h0;
      12'h088: return exp_txstat();
      12'h100: return 32'd128;
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Read: strobe at negedge, sample registered data just after the edge.
  task automatic do_read(logic [11:0] a, string req);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1; bus_rd = 1'b0;
    check(req, bus_rdata, e);
    if (a == 12'h084) m_held = 0;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
    if (a == 12'h080) m_rx_en = d[6];
    if (a == 12'h088) m_tx_en = d[6];
  endtask

  task automatic push(logic [7:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_data = c;
    @(posedge clk); #1; rx_valid = 1'b0;
    if (!m_held) begin m_held = 1; m_char = c; end
    check("R4 rx_ready after push", {31'h0, rx_ready}, 32'h0);
  endtask

  task automatic check_irq(string req, bit e, logic [7:0] v);
    check(req, {31'h0, irq}, {31'h0, e});
    check(req, sys_status, e ? 32'h1000_0000 : 32'h0);
    if (e) check(req, {24'h0, irq_vector}, {24'h0, v});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5EED_C0DE));
    rst_n = 0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0;
    m_held = 0; m_char = 0; m_rx_en = 0; m_tx_en = 0;
    idle(4);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 irq_vector", {24'h0, irq_vector}, 32'h0);
    check("R1 sys_status", sys_status, 32'h0);
    check("R1 bus_rdata", bus_rdata, 32'h0);

    do_read(12'h080, "R2 rx status after reset");
    do_read(12'h088, "R3 tx status ready");
    do_read(12'h084, "R4 empty read returns 0");

    // R4 single holding register, extra input dropped
    push(8'hA5);
    push(8'h3C);
    do_read(12'h080, "R2 rx status shows held");
    do_read(12'h084, "R4 held char returned");
    do_read(12'h084, "R4 consumed, reads 0");
    check("R4 rx_ready after consume", {31'h0, rx_ready}, 32'h1);

    // R2 only bit 6 stored, bit 7 ignored
    do_write(12'h080, 32'hFFFF_FFFF);
    do_read(12'h080, "R2 write stores only enable");
    // R5 receive interrupt
    push(8'h11);
    idle(1);
    check_irq("R5 rx irq raised", 1, 8'hF8);
    // R7 sticky after condition goes away
    do_read(12'h084, "R4 read rx char");
    idle(2);
    check_irq("R7 pending is sticky", 1, 8'hF8);
    do_write(12'h080, 32'h40);
    check_irq("R7 ack clears", 0, 8'h0);
    idle(2);
    check_irq("R7 stays clear without condition", 0, 8'h0);

    // R6 transmit interrupt and priority
    do_write(12'h088, 32'h40);
    idle(1);
    check_irq("R6 tx irq raised", 1, 8'hFC);
    push(8'h22);
    idle(2);
    check_irq("R6 tx vector has priority", 1, 8'hFC);
    do_write(12'h088, 32'h0);
    check_irq("R7 ack by tx status write", 0, 8'h0);
    idle(1);
    check_irq("R7 rx condition re-raises", 1, 8'hF8);
    do_write(12'h080, 32'h0);
    idle(2);
    check_irq("R7 cleared, no condition", 0, 8'h0);
    do_read(12'h084, "R4 drain");
    do_write(12'h088, 32'h40);
    idle(1);
    do_write(12'h088, 32'h40);
    check_irq("R7 ack with enable kept", 0, 8'h0);
    idle(1);
    check_irq("R7 re-raised after ack", 1, 8'hFC);
    do_write(12'h088, 32'h0);

    // R8 transmit data pulse
    do_write(12'h08C, 32'h1234_56C3);
    check("R8 tx_valid", {31'h0, tx_valid}, 32'h1);
    check("R8 tx_data low byte", {24'h0, tx_data}, 32'hC3);
    idle(1);
    check("R8 single-cycle pulse", {31'h0, tx_valid}, 32'h0);

    // R9 constant, sink and unmapped offsets
    do_read(12'h100, "R9 constant 128");
    do_write(12'h100, 32'hFFFF_FFFF);
    do_write(12'h108, 32'hFFFF_FFFF);
    do_write(12'h1F0, 32'hFFFF_FFFF);
    check("R9 no tx from ignored writes", {31'h0, tx_valid}, 32'h0);
    idle(1);
    check_irq("R9 ignored writes raise nothing", 0, 8'h0);
    do_read(12'h080, "R9 rx status untouched");
    do_read(12'h088, "R9 tx status untouched");
    do_read(12'h108, "R9 sink reads 0");
    do_read(12'h1F0, "R9 unmapped reads 0");

    // R10 read data holds between reads
    do_read(12'h100, "R10 read before hold");
    keep = bus_rdata;
    do_write(12'h088, 32'h0);
    idle(3);
    check("R10 rdata holds", bus_rdata, keep);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [11:0] ra;
      op = $urandom_range(0, 7);
      case (op)
        0: push(8'($urandom));
        1: do_read(12'h080, "R2 random rx status");
        2: do_read(12'h084, "R4 random rx data");
        3: do_write(12'h080, $urandom);
        4: do_write(12'h088, ($urandom_range(0, 3) == 0) ? 32'h40 : 32'h0);
        5: begin
          logic [31:0] d;
          d = $urandom;
          do_write(12'h08C, d);
          check("R8 random tx_data", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, d[7:0]});
        end
        6: do_read(12'h088, "R3 random tx status");
        default: begin
          ra = 12'($urandom_range(0, 3)) << 2;
          ra = ra + (($urandom_range(0, 1) == 1) ? 12'h100 : 12'h0C0);
          do_read(ra, "R9 random other offset");
        end
      endcase
      idle(2);
      if (m_tx_en) check_irq("R6 random tx irq", 1, 8'hFC);
      else if (m_rx_en && m_held) check_irq("R5 random rx irq", 1, 8'hF8);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule